// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns a decoded operand specifier into a memory address for a CPU with eight 32-bit address registers. For each request it takes an addressing-mode code, an operand size, a register index, a displacement or absolute field with a width tag, the current program counter and a flag marking the address as an instruction-fetch target. It reads the selected address register through a combinational read port and returns a registered effective address together with a one-cycle valid strobe.

The auto-increment and auto-decrement modes also produce a register write-back value and index. The memory-indirect mode issues one table-read request on a valid/ready channel, waits for the returned 32-bit word and signals completion with a done strobe. Register-direct and immediate operands carry no address and are flagged as such. A small controller steps through the states IDLE, EMIT, IREQ, IWAIT and IDONE. The transitions are: IDLE to EMIT on an accepted non-indirect request; IDLE to IREQ on an accepted indirect request; EMIT back to IDLE after one cycle; IREQ to IWAIT when the request is taken; IWAIT to IDONE when the word returns; IDONE back to IDLE after one cycle.

Top module: `opea_unit`

## Requirements
- R1: Mode code 1 (register indirect) yields the contents of the register selected by `reg_idx` as the address.
- R2: Mode code 2 (register plus displacement) adds the field to the register. Width tag 1 (16-bit) sign-extends field[15:0]; any other tag adds the full 32-bit field. The sum wraps modulo 2^32.
- R3: Mode code 3 (post-increment) yields the register value as the address. It writes back the register plus the step on `wb_idx` = `reg_idx`. The step is 1 for size 0 (byte), 2 for size 1 (word) and 4 for size 2 or 3 (long). The sum wraps.
- R4: Mode code 4 (pre-decrement) subtracts the step from the register, with wrap. It uses the result as both the address and the write-back value.
- R5: Mode code 5 (absolute) extends the field by its width tag. Tag 0 gives 0xFFFFFF followed by field[7:0]. Tag 1 sign-extends field[15:0]. Tag 2 zero-extends field[23:0]. Tag 3 passes all 32 bits.
- R6: Mode code 7 (PC-relative) adds the sign-extended field to `pc`. Width tag 0 takes field[7:0]; any other tag takes field[15:0]. The sum wraps.
- R7: When `fetch_tgt` is high at acceptance, bits 31:24 of the returned address, whether computed or read by the indirect fetch, are zero.
- R8: Mode codes 0 (register direct) and 6 (immediate), and unused codes 9 to 15, raise `no_mem` with `ea_valid` and never raise `wb_valid`.
- R9: Mode code 8 (memory indirect) raises `mem_req_valid` one cycle after acceptance, with address field[7:0] zero-extended. It holds the request until `mem_req_ready`. One cycle after `mem_rsp_valid` it raises `ind_done` for one cycle, with the returned word on `ea_addr`.
- R10: A request is accepted when `in_valid` and `in_ready` are both high. For non-indirect modes, `ea_valid` is high for exactly the one cycle after acceptance. `in_ready` is low while a request is in progress.
- R11: After reset `in_ready` is high and `ea_valid`, `wb_valid`, `mem_req_valid` and `ind_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request can be taken |
| mode | input | 4 | Addressing-mode code |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| reg_idx | input | 3 | Address register index |
| field | input | 32 | Displacement or absolute field |
| field_w | input | 2 | Field width tag: 0=8, 1=16, 2=24, 3=32 bits |
| pc | input | 32 | Current program counter |
| fetch_tgt | input | 1 | Address is an instruction-fetch target |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | 32 | Register file read data |
| ea_valid | output | 1 | Address strobe for non-indirect modes |
| ea_addr | output | 32 | Effective address |
| no_mem | output | 1 | Operand has no memory address (valid with `ea_valid`) |
| wb_valid | output | 1 | Register write-back strobe |
| wb_idx | output | 3 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| mem_req_valid | output | 1 | Indirect table read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | 32 | Indirect table address |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | 32 | Returned word |
| ind_done | output | 1 | Indirect address ready strobe |

## Verification
The checker watches these properties on every cycle:
- the strobe pulses are one cycle long and never overlap;
- every non-indirect acceptance produces a strobe on the next cycle;
- the fetch mask holds;
- the indirect request stays stable until it is taken and its address stays within 8 bits;
- the relation between address and write-back holds for both auto-update modes;
- operands flagged as having no address never write back.

The exact address values can only be shown by the bench's scenarios:
- the extension rule for each width tag;
- wrap-around at 2^32;
- step sizes for byte, word and long;
- PC-relative sums;
- the indirect word under back-pressure.

// File: rtl/opea_pkg.sv
package opea_pkg;

    // addressing-mode codes
    localparam logic [3:0] AM_REG     = 4'd0;
    localparam logic [3:0] AM_IND     = 4'd1;
    localparam logic [3:0] AM_DISP    = 4'd2;
    localparam logic [3:0] AM_POSTINC = 4'd3;
    localparam logic [3:0] AM_PREDEC  = 4'd4;
    localparam logic [3:0] AM_ABS     = 4'd5;
    localparam logic [3:0] AM_IMM     = 4'd6;
    localparam logic [3:0] AM_PCREL   = 4'd7;
    localparam logic [3:0] AM_MEMIND  = 4'd8;

    // field width tags
    localparam logic [1:0] WT_8  = 2'd0;
    localparam logic [1:0] WT_16 = 2'd1;
    localparam logic [1:0] WT_24 = 2'd2;
    localparam logic [1:0] WT_32 = 2'd3;

    // operand sizes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EMIT,
        ST_IREQ,
        ST_IWAIT,
        ST_IDONE
    } ctl_state_e;

endpackage

// File: rtl/opea_ext.sv
module opea_ext #(
    parameter int AW = 32,
    parameter int IW = 8,
    parameter int FB = 24
) (
    input  logic [AW-1:0] field,
    output logic [AW-1:0] disp16_x,
    output logic [AW-1:0] abs8_x,
    output logic [AW-1:0] abs16_x,
    output logic [AW-1:0] abs24_x,
    output logic [AW-1:0] pc8_x,
    output logic [AW-1:0] ind_addr,
    output logic [AW-1:0] fetch_mask
);

    // 16-bit values are sign-extended for displacement, absolute and PC-relative use
    assign disp16_x = {{(AW-16){field[15]}}, field[15:0]};
    assign abs16_x  = disp16_x;
    assign abs8_x   = {{(AW-8){1'b1}}, field[7:0]};
    assign abs24_x  = {{(AW-24){1'b0}}, field[23:0]};
    assign pc8_x    = {{(AW-8){field[7]}}, field[7:0]};
    assign ind_addr = {{(AW-IW){1'b0}}, field[IW-1:0]};

    for (genvar gi = 0; gi < AW; gi++) begin : g_mask
        if (gi < FB) begin : g_keep
            assign fetch_mask[gi] = 1'b1;
        end else begin : g_drop
            assign fetch_mask[gi] = 1'b0;
        end
    end

endmodule

// File: rtl/opea_calc.sv
module opea_calc
    import opea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [3:0]    mode,
    input  logic [1:0]    size,
    input  logic [1:0]    field_w,
    input  logic [AW-1:0] field,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] rdata,
    input  logic [AW-1:0] disp16_x,
    input  logic [AW-1:0] abs8_x,
    input  logic [AW-1:0] abs16_x,
    input  logic [AW-1:0] abs24_x,
    input  logic [AW-1:0] pc8_x,
    input  logic [AW-1:0] ind_addr,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wb_data,
    output logic          wb_en,
    output logic          no_mem,
    output logic          is_ind
);

    logic [AW-1:0] step;
    logic [AW-1:0] dec_val;
    logic [AW-1:0] disp_sel;
    logic [AW-1:0] pcd_sel;
    logic [AW-1:0] abs_sel;

    always_comb begin
        unique case (size)
            SZ_BYTE: step = AW'(1);
            SZ_WORD: step = AW'(2);
            default: step = AW'(4);
        endcase
    end

    assign dec_val  = rdata - step;
    assign disp_sel = (field_w == WT_16) ? disp16_x : field;
    assign pcd_sel  = (field_w == WT_8) ? pc8_x : disp16_x;

    always_comb begin
        unique case (field_w)
            WT_8:    abs_sel = abs8_x;
            WT_16:   abs_sel = abs16_x;
            WT_24:   abs_sel = abs24_x;
            default: abs_sel = field;
        endcase
    end

    always_comb begin
        ea      = '0;
        wb_data = '0;
        wb_en   = 1'b0;
        no_mem  = 1'b0;
        is_ind  = 1'b0;
        unique case (mode)
            AM_IND:     ea = rdata;
            AM_DISP:    ea = rdata + disp_sel;
            AM_POSTINC: begin
                ea      = rdata;
                wb_data = rdata + step;
                wb_en   = 1'b1;
            end
            AM_PREDEC:  begin
                ea      = dec_val;
                wb_data = dec_val;
                wb_en   = 1'b1;
            end
            AM_ABS:     ea = abs_sel;
            AM_PCREL:   ea = pc + pcd_sel;
            AM_MEMIND:  begin
                ea     = ind_addr;
                is_ind = 1'b1;
            end
            default:    no_mem = 1'b1;
        endcase
    end

endmodule

// File: rtl/opea_ctrl.sv
module opea_ctrl
    import opea_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic is_ind,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic in_ready,
    output logic load_in,
    output logic load_rsp,
    output logic emit,
    output logic req_active,
    output logic done
);

    ctl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = is_ind ? ST_IREQ : ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
            ST_IREQ:  if (req_ready) state_d = ST_IWAIT;
            ST_IWAIT: if (rsp_valid) state_d = ST_IDONE;
            ST_IDONE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready   = 1'b0;
        load_in    = 1'b0;
        load_rsp   = 1'b0;
        emit       = 1'b0;
        req_active = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin
                in_ready = 1'b1;
                load_in  = in_valid;
            end
            ST_EMIT:  emit = 1'b1;
            ST_IREQ:  req_active = 1'b1;
            ST_IWAIT: load_rsp = rsp_valid;
            ST_IDONE: done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/opea_unit.sv
module opea_unit
    import opea_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NREG  = 8,
    parameter int IW    = 8,
    parameter int FB    = 24,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [3:0]      mode,
    input  logic [1:0]      size,
    input  logic [IDXW-1:0] reg_idx,
    input  logic [AW-1:0]   field,
    input  logic [1:0]      field_w,
    input  logic [AW-1:0]   pc,
    input  logic            fetch_tgt,
    output logic [IDXW-1:0] rf_rd_idx,
    input  logic [AW-1:0]   rf_rd_data,
    output logic            ea_valid,
    output logic [AW-1:0]   ea_addr,
    output logic            no_mem,
    output logic            wb_valid,
    output logic [IDXW-1:0] wb_idx,
    output logic [AW-1:0]   wb_data,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [AW-1:0]   mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [AW-1:0]   mem_rsp_data,
    output logic            ind_done
);

    logic [AW-1:0] disp16_x, abs8_x, abs16_x, abs24_x, pc8_x, ind_addr, fetch_mask;
    logic [AW-1:0] ea_c, wb_c;
    logic          wb_en_c, no_mem_c, is_ind_c;
    logic          load_in, load_rsp, emit, req_active, done;

    logic [AW-1:0]   ea_q, wb_q, req_q;
    logic [IDXW-1:0] wb_idx_q;
    logic            wb_en_q, no_mem_q, tgt_q;

    assign rf_rd_idx = reg_idx;

    opea_ext #(.AW(AW), .IW(IW), .FB(FB)) u_ext (
        .field      (field),
        .disp16_x   (disp16_x),
        .abs8_x     (abs8_x),
        .abs16_x    (abs16_x),
        .abs24_x    (abs24_x),
        .pc8_x      (pc8_x),
        .ind_addr   (ind_addr),
        .fetch_mask (fetch_mask)
    );

    opea_calc #(.AW(AW)) u_calc (
        .mode     (mode),
        .size     (size),
        .field_w  (field_w),
        .field    (field),
        .pc       (pc),
        .rdata    (rf_rd_data),
        .disp16_x (disp16_x),
        .abs8_x   (abs8_x),
        .abs16_x  (abs16_x),
        .abs24_x  (abs24_x),
        .pc8_x    (pc8_x),
        .ind_addr (ind_addr),
        .ea       (ea_c),
        .wb_data  (wb_c),
        .wb_en    (wb_en_c),
        .no_mem   (no_mem_c),
        .is_ind   (is_ind_c)
    );

    opea_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .is_ind     (is_ind_c),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .in_ready   (in_ready),
        .load_in    (load_in),
        .load_rsp   (load_rsp),
        .emit       (emit),
        .req_active (req_active),
        .done       (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q     <= '0;
            wb_q     <= '0;
            req_q    <= '0;
            wb_idx_q <= '0;
            wb_en_q  <= 1'b0;
            no_mem_q <= 1'b0;
            tgt_q    <= 1'b0;
        end else if (load_in) begin
            ea_q     <= fetch_tgt ? (ea_c & fetch_mask) : ea_c;
            wb_q     <= wb_c;
            req_q    <= ind_addr;
            wb_idx_q <= reg_idx;
            wb_en_q  <= wb_en_c;
            no_mem_q <= no_mem_c;
            tgt_q    <= fetch_tgt;
        end else if (load_rsp) begin
            ea_q <= tgt_q ? (mem_rsp_data & fetch_mask) : mem_rsp_data;
        end
    end

    assign ea_valid      = emit;
    assign ea_addr       = ea_q;
    assign no_mem        = emit & no_mem_q;
    assign wb_valid      = emit & wb_en_q;
    assign wb_idx        = wb_idx_q;
    assign wb_data       = wb_q;
    assign mem_req_valid = req_active;
    assign mem_req_addr  = req_q;
    assign ind_done      = done;

endmodule

// File: rtl/opea_unit_chk.sv
module opea_unit_chk
    import opea_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [3:0]  mode,
    input logic        fetch_tgt,
    input logic        ea_valid,
    input logic [31:0] ea_addr,
    input logic        no_mem,
    input logic        wb_valid,
    input logic [31:0] wb_data,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        ind_done
);

    logic acc;
    assign acc = in_valid && in_ready;

    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> !ea_valid);

    a_r10_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode != AM_MEMIND) |=> (ea_valid && !in_ready));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ind_done |=> !ind_done);

    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_valid && ind_done));

    a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && fetch_tgt && mode != AM_MEMIND) |=> (ea_addr[31:24] == 8'h00));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[31:8] == 24'h0));

    a_r8_nowb: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && no_mem) |-> !wb_valid);

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode == AM_POSTINC && !fetch_tgt) |=>
            (wb_valid && ((wb_data - ea_addr) == 32'd1 || (wb_data - ea_addr) == 32'd2 ||
                          (wb_data - ea_addr) == 32'd4)));

    a_r4_same: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode == AM_PREDEC && !fetch_tgt) |=> (wb_valid && wb_data == ea_addr));

endmodule

bind opea_unit opea_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .mode          (mode),
    .fetch_tgt     (fetch_tgt),
    .ea_valid      (ea_valid),
    .ea_addr       (ea_addr),
    .no_mem        (no_mem),
    .wb_valid      (wb_valid),
    .wb_data       (wb_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .ind_done      (ind_done)
);

// File: tb/tb_opea_unit.sv
`timescale 1ns/1ps
module tb_opea_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] field = '0;
    logic [1:0]  field_w = '0;
    logic [31:0] pc = '0;
    logic        fetch_tgt = 1'b0;
    logic [2:0]  rf_rd_idx;
    logic [31:0] rf_rd_data;
    logic        ea_valid, no_mem, wb_valid, mem_req_valid, ind_done;
    logic [31:0] ea_addr, wb_data, mem_req_addr;
    logic [2:0]  wb_idx;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    logic [31:0] regs [8];
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    assign rf_rd_data = regs[rf_rd_idx];

    opea_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .size(size), .reg_idx(reg_idx), .field(field), .field_w(field_w),
        .pc(pc), .fetch_tgt(fetch_tgt), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .ea_valid(ea_valid), .ea_addr(ea_addr), .no_mem(no_mem), .wb_valid(wb_valid),
        .wb_idx(wb_idx), .wb_data(wb_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .ind_done(ind_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one non-indirect operation, checked on the strobe cycle and the cycle after
    task automatic run_op(input string req, input logic [3:0] m, input logic [1:0] sz,
                          input logic [2:0] idx, input logic [31:0] f, input logic [1:0] fw,
                          input logic [31:0] p, input logic ft, input logic [31:0] exp_ea,
                          input logic exp_nm, input logic exp_wb, input logic [31:0] exp_wbd);
        @(negedge clk);
        chk({req, " ready"}, {31'd0, in_ready}, 32'd1);
        mode = m; size = sz; reg_idx = idx; field = f; field_w = fw; pc = p; fetch_tgt = ft;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " ea_valid R10"}, {31'd0, ea_valid}, 32'd1);
        chk({req, " busy R10"}, {31'd0, in_ready}, 32'd0);
        chk({req, " no_mem"}, {31'd0, no_mem}, {31'd0, exp_nm});
        chk({req, " wb_valid"}, {31'd0, wb_valid}, {31'd0, exp_wb});
        if (!exp_nm) chk({req, " ea"}, ea_addr, exp_ea);
        if (exp_wb) begin
            chk({req, " wb_data"}, wb_data, exp_wbd);
            chk({req, " wb_idx"}, {29'd0, wb_idx}, {29'd0, idx});
        end
        @(negedge clk);
        chk({req, " strobe ends R10"}, {31'd0, ea_valid}, 32'd0);
    endtask

    // memory-indirect operation with a back-pressured request
    task automatic run_ind(input string req, input logic [31:0] f, input logic ft,
                           input logic [31:0] word, input logic [31:0] exp_ea);
        @(negedge clk);
        mode = 4'd8; field = f; field_w = 2'd0; fetch_tgt = ft; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " req_valid R9"}, {31'd0, mem_req_valid}, 32'd1);
        chk({req, " req_addr R9"}, mem_req_addr, {24'd0, f[7:0]});
        chk({req, " no ea_valid R9"}, {31'd0, ea_valid}, 32'd0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk({req, " req held R9"}, {31'd0, mem_req_valid}, 32'd1);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk({req, " req dropped R9"}, {31'd0, mem_req_valid}, 32'd0);
        chk({req, " still busy R10"}, {31'd0, in_ready}, 32'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = word;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk({req, " done R9"}, {31'd0, ind_done}, 32'd1);
        chk({req, " ind ea R9"}, ea_addr, exp_ea);
        @(negedge clk);
        chk({req, " done ends R9"}, {31'd0, ind_done}, 32'd0);
    endtask

    task automatic t_reset();
        chk("reset in_ready R11", {31'd0, in_ready}, 32'd1);
        chk("reset ea_valid R11", {31'd0, ea_valid}, 32'd0);
        chk("reset wb_valid R11", {31'd0, wb_valid}, 32'd0);
        chk("reset req R11", {31'd0, mem_req_valid}, 32'd0);
        chk("reset done R11", {31'd0, ind_done}, 32'd0);
    endtask

    task automatic t_indirect();
        run_op("R1 ER4", 4'd1, 2'd0, 3'd4, 32'h0, 2'd0, 32'h0, 1'b0, 32'h1234_5678, 1'b0, 1'b0, 32'h0);
        run_op("R7 ER6 fetch", 4'd1, 2'd0, 3'd6, 32'h0, 2'd0, 32'h0, 1'b1, 32'h0000_0100, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_disp();
        run_op("R2 d16 neg", 4'd2, 2'd0, 3'd0, 32'h0000_FFF0, 2'd1, 32'h0, 1'b0, 32'h0000_0FF0, 1'b0, 1'b0, 32'h0);
        run_op("R2 d16 pos", 4'd2, 2'd0, 3'd0, 32'h0000_7FFF, 2'd1, 32'h0, 1'b0, 32'h0000_8FFF, 1'b0, 1'b0, 32'h0);
        run_op("R2 d32 wrap", 4'd2, 2'd0, 3'd2, 32'h0000_0005, 2'd3, 32'h0, 1'b0, 32'h0000_0003, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_postinc();
        run_op("R3 byte", 4'd3, 2'd0, 3'd7, 32'h0, 2'd0, 32'h0, 1'b0, 32'h10, 1'b0, 1'b1, 32'h11);
        run_op("R3 word", 4'd3, 2'd1, 3'd7, 32'h0, 2'd0, 32'h0, 1'b0, 32'h10, 1'b0, 1'b1, 32'h12);
        run_op("R3 long wrap", 4'd3, 2'd2, 3'd2, 32'h0, 2'd0, 32'h0, 1'b0, 32'hFFFF_FFFE, 1'b0, 1'b1, 32'h2);
    endtask

    task automatic t_predec();
        run_op("R4 long", 4'd4, 2'd2, 3'd0, 32'h0, 2'd0, 32'h0, 1'b0, 32'h0FFC, 1'b0, 1'b1, 32'h0FFC);
        run_op("R4 byte wrap", 4'd4, 2'd0, 3'd5, 32'h0, 2'd0, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_FFFF);
        run_op("R4 word", 4'd4, 2'd1, 3'd3, 32'h0, 2'd0, 32'h0, 1'b0, 32'h7FFF_FFFE, 1'b0, 1'b1, 32'h7FFF_FFFE);
    endtask

    task automatic t_abs();
        run_op("R5 abs8", 4'd5, 2'd0, 3'd0, 32'h1234_56A5, 2'd0, 32'h0, 1'b0, 32'hFFFF_FFA5, 1'b0, 1'b0, 32'h0);
        run_op("R5 abs16 neg", 4'd5, 2'd0, 3'd0, 32'h0000_8001, 2'd1, 32'h0, 1'b0, 32'hFFFF_8001, 1'b0, 1'b0, 32'h0);
        run_op("R5 abs16 pos", 4'd5, 2'd0, 3'd0, 32'hABCD_7001, 2'd1, 32'h0, 1'b0, 32'h0000_7001, 1'b0, 1'b0, 32'h0);
        run_op("R5 abs24", 4'd5, 2'd0, 3'd0, 32'h1280_0000, 2'd2, 32'h0, 1'b0, 32'h0080_0000, 1'b0, 1'b0, 32'h0);
        run_op("R5 abs32", 4'd5, 2'd0, 3'd0, 32'hDEAD_BEEF, 2'd3, 32'h0, 1'b0, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0);
        run_op("R7 abs8 fetch", 4'd5, 2'd0, 3'd0, 32'h0000_00A5, 2'd0, 32'h0, 1'b1, 32'h00FF_FFA5, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_pcrel();
        run_op("R6 pc8 neg", 4'd7, 2'd0, 3'd0, 32'h0000_0080, 2'd0, 32'h2000, 1'b0, 32'h0000_1F80, 1'b0, 1'b0, 32'h0);
        run_op("R6 pc16 pos", 4'd7, 2'd0, 3'd0, 32'h0000_0100, 2'd1, 32'h2000, 1'b0, 32'h0000_2100, 1'b0, 1'b0, 32'h0);
        run_op("R6 pc8 to zero", 4'd7, 2'd0, 3'd0, 32'h0000_00F0, 2'd0, 32'h10, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
        run_op("R6 pc16 wrap", 4'd7, 2'd0, 3'd0, 32'h0000_FFF0, 2'd1, 32'h4, 1'b0, 32'hFFFF_FFF4, 1'b0, 1'b0, 32'h0);
        run_op("R7 pc16 fetch", 4'd7, 2'd0, 3'd0, 32'h0000_FFF0, 2'd1, 32'h4, 1'b1, 32'h00FF_FFF4, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_nomem();
        run_op("R8 regdir", 4'd0, 2'd2, 3'd1, 32'h0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0);
        run_op("R8 imm", 4'd6, 2'd2, 3'd1, 32'h55, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0);
        run_op("R8 unused code", 4'd12, 2'd0, 3'd1, 32'h0, 2'd0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0);
    endtask

    task automatic t_memind();
        run_ind("R9 plain", 32'hFFFF_FF3C, 1'b0, 32'hCAFE_1234, 32'hCAFE_1234);
        run_ind("R7 R9 fetch", 32'h0000_00C8, 1'b1, 32'hCAFE_1234, 32'h00FE_1234);
    endtask

    initial begin
        regs[0] = 32'h0000_1000; regs[1] = 32'h00FF_FFF0;
        regs[2] = 32'hFFFF_FFFE; regs[3] = 32'h8000_0000;
        regs[4] = 32'h1234_5678; regs[5] = 32'h0000_0000;
        regs[6] = 32'hAB00_0100; regs[7] = 32'h0000_0010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_indirect();
        t_disp();
        t_postinc();
        t_predec();
        t_abs();
        t_pcrel();
        t_nomem();
        t_memind();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule